// File: doc/BRIEF.md
# Middle-Outward Address-Complement Memory Tester

This block is a built-in self-test engine for a byte-wide synchronous RAM. It divides the address space into equal blocks (4 KiB by default) and, for each block in a contiguous run, writes every location and then reads every location back and compares. The visiting order starts just below the middle of the block. Each offset is followed at once by its bitwise complement inside the block, and the pair index then steps downward. Consecutive accesses therefore flip nearly every offset bit, which stresses the RAM's address decoding and buffering far more than a linear sweep does.

The byte written at each location is a hash of its own address plus a rolling base value. After each complete pass over all selected blocks the base advances by a fixed odd step, so every location sees a different value on each pass. The tester runs without end once started. On the first mismatch it freezes, raises an error flag and holds the failing address, block, expected byte and the differing bits. A restart pulse lets it carry on from the access after the failing one.

Top module: `memtest_bist`

## Requirements
- R1: After reset `err` is 0, `mem_we` is 0, `pass_cnt` is 0 and all captured error fields are 0. The tester stays idle until `start` is sampled high with `blk_count` nonzero. A `start` with `blk_count` zero is ignored. A `start` while testing or halted is ignored.
- R2: Within a block the offset sequence is pairs (o, o XOR (2^BLK_W-1)) for o running from 2^(BLK_W-1)-1 down to 0. The complement always comes directly after its partner.
- R3: A block is first written over the whole R2 sequence (one write per cycle, `mem_we`=1). It is then read back over the same sequence before the tester moves to the next block.
- R4: The byte for address a is ((rotl1(a[7:0]) << 1) + a[15:8] + base) mod 256. Here rotl1 moves bit 7 to bit 0, and address bits above ADDR_W-1 count as 0.
- R5: Each read holds the same address with `mem_we`=0 for two cycles. `mem_rdata` is compared in the second cycle, which allows for one cycle of RAM read latency.
- R6: The block number occupies `mem_addr[ADDR_W-1:BLK_W]`. Blocks `first_blk`, `first_blk`+1, … are tested for `blk_count` blocks, with the block number wrapping modulo 2^(ADDR_W-BLK_W).
- R7: After the read phase of the last block, the base rises by 135 mod 256 and `pass_cnt` rises by 1. Testing then continues with the first block, indefinitely.
- R8: On a read mismatch the tester halts with `err`=1 and issues no writes. It captures the failing address, the block number, the expected byte, and the expected byte XOR the read byte, where a 1 marks a bad bit. These values hold while halted.
- R9: A `restart` pulse while halted clears `err` and resumes with the access that follows the failed one; the captured fields keep their values. A `restart` at any other time is ignored.
- R10: Each accepted `start` begins at the first block with base 0 and `pass_cnt` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin testing with the current configuration (idle only) |
| restart | input | 1 | Leave the halt and resume |
| first_blk | input | ADDR_W-BLK_W | First block number to test |
| blk_count | input | ADDR_W-BLK_W+1 | Number of contiguous blocks |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | 8 | RAM write data (the expected byte) |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | 8 | RAM read data, valid one cycle after its address |
| err | output | 1 | Halted on a mismatch |
| err_addr | output | ADDR_W | Captured failing address |
| err_blk | output | ADDR_W-BLK_W | Captured block number |
| err_exp | output | 8 | Captured expected byte |
| err_bits | output | 8 | Captured expected XOR read byte |
| pass_cnt | output | CYC_W | Completed full passes |

## Verification
The assertions assume a RAM that returns read data exactly one cycle after the address. They also assume that `start` and `restart` are sampled only on clock edges and that the configuration inputs are stable when `start` is taken. The bench models a one-cycle RAM with an optional stuck-at-1 bit. It drives every control input on the falling edge and pulses `start` and `restart` at moments that must be ignored, which keeps these assumptions intact. One run crosses the block-number wrap and injects a fault to exercise the halt and resume path.

// File: rtl/memtest_pkg.sv
// Package: shared state encoding and constants for the memory tester.
// Assumes nothing beyond being compiled before its users.
package memtest_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_RD_ISSUE,
        ST_RD_CHECK,
        ST_HALT
    } mt_state_t;

    localparam logic [7:0] BASE_STEP = 8'd135;
endpackage

// File: rtl/mt_pattern.sv
// Test byte generator: hashes an address with the rolling base.
// Assumes 9 <= ADDR_W <= 16 so the high byte is a[ADDR_W-1:8].
module mt_pattern #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        base,
    output logic [7:0]        pattern
);
    logic [15:0] wide;
    logic [7:0]  rot;

    // Rotate the low byte left by one, double it, add high byte and base.
    always_comb begin
        wide    = 16'(addr);
        rot     = {wide[6:0], wide[7]};
        pattern = {rot[6:0], 1'b0} + wide[15:8] + base;
    end
endmodule

// File: rtl/mt_walk.sv
// Address walker: produces the middle-outward complement-pair sequence
// inside the current block and tracks which block of the run is active.
// Assumes step and adv_blk are never raised together with load.
module mt_walk #(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [ADDR_W-BLK_W-1:0] cfg_first,
    input  logic [ADDR_W-BLK_W:0]   cfg_cnt,
    input  logic                    step,
    input  logic                    adv_blk,
    output logic [ADDR_W-1:0]       addr,
    output logic [ADDR_W-BLK_W-1:0] blk,
    output logic                    last_loc,
    output logic                    last_blk
);
    localparam int NB_W  = ADDR_W - BLK_W;
    localparam int OFF_W = BLK_W - 1;
    localparam int CNT_W = NB_W + 1;
    localparam logic [OFF_W-1:0] MID = {OFF_W{1'b1}};

    logic [NB_W-1:0]  first_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic [OFF_W-1:0] off_q;
    logic             half_q;

    // Form the address and the end-of-block / end-of-run flags.
    always_comb begin
        blk      = first_q + idx_q[NB_W-1:0];
        addr     = {blk, half_q, (half_q ? ~off_q : off_q)};
        last_loc = half_q && (off_q == '0);
        last_blk = (idx_q == (cnt_q - CNT_W'(1)));
    end

    // Advance the pair index, the half select and the block index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            off_q   <= MID;
            half_q  <= 1'b0;
        end else if (load) begin
            first_q <= cfg_first;
            cnt_q   <= cfg_cnt;
            idx_q   <= '0;
            off_q   <= MID;
            half_q  <= 1'b0;
        end else begin
            if (step) begin
                if (last_loc) begin
                    off_q  <= MID;
                    half_q <= 1'b0;
                end else if (half_q) begin
                    off_q  <= off_q - OFF_W'(1);
                    half_q <= 1'b0;
                end else begin
                    half_q <= 1'b1;
                end
            end
            if (adv_blk) begin
                idx_q <= last_blk ? '0 : idx_q + CNT_W'(1);
            end
        end
    end

    // R2: the complement of an offset is the very next location.
    a_r2_complement_next: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !half_q && !load) |=>
        (addr[BLK_W-1:0] == ~$past(addr[BLK_W-1:0])));

    // R2: after a complement the pair index drops by one.
    a_r2_descend: assert property (@(posedge clk) disable iff (!rst_n)
        (step && half_q && !last_loc && !load) |=>
        (addr[BLK_W-1:0] == BLK_W'($past(~addr[BLK_W-1:0]) - BLK_W'(1))));

    // R3: the end of a sweep rewinds to the middle of the block.
    a_r3_rewind_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last_loc && !load) |=> (addr[BLK_W-1:0] == {1'b0, MID}));

    // R7: finishing the last block returns to the first block.
    a_r7_back_to_first: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_blk && last_blk && !load) |=> (blk == first_q));
endmodule

// File: rtl/mt_err_capture.sv
// Error capture: latches the failing access details on a mismatch.
// Assumes capture is a single-cycle pulse from the controller.
module mt_err_capture #(
    parameter int ADDR_W = 16,
    parameter int NB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NB_W-1:0]   blk,
    input  logic [7:0]        exp_byte,
    input  logic [7:0]        got_byte,
    output logic [ADDR_W-1:0] err_addr,
    output logic [NB_W-1:0]   err_blk,
    output logic [7:0]        err_exp,
    output logic [7:0]        err_bits
);
    // Hold the last failure until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_addr <= '0;
            err_blk  <= '0;
            err_exp  <= '0;
            err_bits <= '0;
        end else if (capture) begin
            err_addr <= addr;
            err_blk  <= blk;
            err_exp  <= exp_byte;
            err_bits <= exp_byte ^ got_byte;
        end
    end
endmodule

// File: rtl/memtest_bist.sv
// Memory tester top: sequences write and read sweeps over a run of
// blocks, compares read data, halts on error and resumes on restart.
// Assumes a RAM with exactly one cycle of read latency.
module memtest_bist
    import memtest_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 12,
    parameter int CYC_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    restart,
    input  logic [ADDR_W-BLK_W-1:0] first_blk,
    input  logic [ADDR_W-BLK_W:0]   blk_count,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [7:0]              mem_wdata,
    output logic                    mem_we,
    input  logic [7:0]              mem_rdata,
    output logic                    err,
    output logic [ADDR_W-1:0]       err_addr,
    output logic [ADDR_W-BLK_W-1:0] err_blk,
    output logic [7:0]              err_exp,
    output logic [7:0]              err_bits,
    output logic [CYC_W-1:0]        pass_cnt
);
    localparam int NB_W = ADDR_W - BLK_W;

    mt_state_t        state_q, state_d;
    logic [7:0]       base_q;
    logic [CYC_W-1:0] pass_q;
    logic [ADDR_W-1:0] walk_addr;
    logic [NB_W-1:0]  walk_blk;
    logic             last_loc, last_blk;
    logic [7:0]       exp_byte;
    logic             launch, mismatch, advance, step, adv_blk, wrap_pass;

    mt_walk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(launch),
        .cfg_first(first_blk), .cfg_cnt(blk_count),
        .step(step), .adv_blk(adv_blk),
        .addr(walk_addr), .blk(walk_blk),
        .last_loc(last_loc), .last_blk(last_blk)
    );

    mt_pattern #(.ADDR_W(ADDR_W)) u_pat (
        .addr(walk_addr), .base(base_q), .pattern(exp_byte)
    );

    mt_err_capture #(.ADDR_W(ADDR_W), .NB_W(NB_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .capture(mismatch),
        .addr(walk_addr), .blk(walk_blk),
        .exp_byte(exp_byte), .got_byte(mem_rdata),
        .err_addr(err_addr), .err_blk(err_blk),
        .err_exp(err_exp), .err_bits(err_bits)
    );

    // Decode the control events of the current cycle.
    always_comb begin
        launch    = (state_q == ST_IDLE) && start && (blk_count != '0);
        mismatch  = (state_q == ST_RD_CHECK) && (mem_rdata != exp_byte);
        advance   = ((state_q == ST_RD_CHECK) && !mismatch) ||
                    ((state_q == ST_HALT) && restart);
        step      = (state_q == ST_WRITE) || advance;
        adv_blk   = advance && last_loc;
        wrap_pass = adv_blk && last_blk;
    end

    // Next-state selection for the sweep controller.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (launch) state_d = ST_WRITE;
            ST_WRITE:    if (last_loc) state_d = ST_RD_ISSUE;
            ST_RD_ISSUE: state_d = ST_RD_CHECK;
            ST_RD_CHECK: if (mismatch) state_d = ST_HALT;
                         else state_d = last_loc ? ST_WRITE : ST_RD_ISSUE;
            ST_HALT:     if (restart) state_d = last_loc ? ST_WRITE : ST_RD_ISSUE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State, rolling base and pass counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            pass_q  <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                base_q <= '0;
                pass_q <= '0;
            end else if (wrap_pass) begin
                base_q <= base_q + BASE_STEP;
                pass_q <= pass_q + CYC_W'(1);
            end
        end
    end

    // Drive the RAM port and status outputs.
    always_comb begin
        mem_addr  = walk_addr;
        mem_wdata = exp_byte;
        mem_we    = (state_q == ST_WRITE);
        err       = (state_q == ST_HALT);
        pass_cnt  = pass_q;
    end

    // R5: an issued read is compared one cycle later at the same address.
    a_r5_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ISSUE) |=> ((state_q == ST_RD_CHECK) && $stable(mem_addr)));

    // R8: a mismatch halts and records address and differing bits.
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> (err && !mem_we && (err_addr == $past(mem_addr)) &&
                      (err_bits == $past(mem_rdata ^ mem_wdata))));

    // R8: while halted nothing moves.
    a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !restart) |=> (err && $stable(mem_addr) && $stable(err_addr) &&
                               $stable(err_bits) && $stable(pass_cnt)));

    // R9: restart leaves the halt and keeps the captured details.
    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (err && restart) |=> (!err && $stable(err_addr) && $stable(err_exp)));

    // R7: a completed pass bumps the counter by exactly one.
    a_r7_pass_step: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pass |=> (pass_cnt == $past(pass_cnt) + CYC_W'(1)));
endmodule

// File: tb/memtest_bist_tb.sv
`timescale 1ns/1ps
module memtest_bist_tb;
    localparam int AW  = 12;
    localparam int BW  = 8;
    localparam int NBW = AW - BW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n, start, restart;
    logic [NBW-1:0] first_blk;
    logic [NBW:0]   blk_count;
    logic [AW-1:0]  mem_addr, err_addr;
    logic [7:0]     mem_wdata, mem_rdata, err_exp, err_bits;
    logic           mem_we, err;
    logic [NBW-1:0] err_blk;
    logic [15:0]    pass_cnt;

    memtest_bist #(.ADDR_W(AW), .BLK_W(BW), .CYC_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .restart(restart),
        .first_blk(first_blk), .blk_count(blk_count),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .err(err), .err_addr(err_addr),
        .err_blk(err_blk), .err_exp(err_exp), .err_bits(err_bits),
        .pass_cnt(pass_cnt)
    );

    // RAM model: one-cycle read latency, optional stuck-at-1 bit.
    logic [7:0]    ram [0:(1<<AW)-1];
    logic          fault_on = 1'b0;
    logic [AW-1:0] fault_addr = '0;
    int            fault_bit = 0;
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr] |
                     ((fault_on && mem_addr == fault_addr) ? 8'(1 << fault_bit) : 8'h00);
    end

    typedef struct packed {
        logic [AW-1:0] a;
        logic          we;
        logic [7:0]    d;
        logic          chk;
        logic [15:0]   p;
    } ent_t;
    ent_t q[$];

    int n_chk = 0, n_fail = 0, n_halts = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ref_byte(int addr, int base);
        int lo, rot;
        lo  = addr & 255;
        rot = ((lo << 1) | (lo >> 7)) & 255;
        return 8'((rot * 2 + (addr >> 8) + base) & 255);
    endfunction

    // Expected per-cycle RAM traffic from the requirements (R2..R7, R10).
    task automatic build(int first, int cnt, int passes);
        for (int p = 0; p < passes; p++)
            for (int b = 0; b < cnt; b++)
                for (int ph = 0; ph < 2; ph++)
                    for (int o = (1 << (BW-1)) - 1; o >= 0; o--)
                        for (int h = 0; h < 2; h++) begin
                            int blk, a;
                            ent_t e;
                            blk   = (first + b) % (1 << NBW);
                            a     = (blk << BW) | (h != 0 ? (o ^ ((1 << BW) - 1)) : o);
                            e.a   = AW'(a);
                            e.d   = ref_byte(a, (135 * p) % 256);
                            e.p   = 16'(p);
                            e.we  = (ph == 0);
                            e.chk = 1'b0;
                            q.push_back(e);
                            if (ph == 1) begin
                                e.chk = 1'b1;
                                q.push_back(e);
                            end
                        end
    endtask

    // Compare DUT against the expected queue each cycle; poke ignored inputs once.
    task automatic run_queue(int poke_at);
        int cyc = 0;
        while (q.size() > 0 && n_fail < 50) begin
            ent_t e;
            @(negedge clk);
            start   = 1'b0;
            restart = 1'b0;
            e = q.pop_front();
            check("R2 address order", 32'(mem_addr), 32'(e.a));
            check("R3 write enable", 32'(mem_we), 32'(e.we));
            if (e.we) check("R4 write byte", 32'(mem_wdata), 32'(e.d));
            check("R7 pass count", 32'(pass_cnt), 32'(e.p));
            check("R9 err low while running", 32'(err), 32'd0);
            if (cyc == poke_at) begin
                start   = 1'b1;   // R1: ignored while testing
                restart = 1'b1;   // R9: ignored when not halted
            end
            if (e.chk && fault_on && e.a == fault_addr && !e.d[fault_bit]) begin
                @(negedge clk);
                n_halts++;
                check("R8 err raised", 32'(err), 32'd1);
                check("R8 captured address", 32'(err_addr), 32'(e.a));
                check("R8 captured block", 32'(err_blk), 32'(e.a >> BW));
                check("R8 captured expected", 32'(err_exp), 32'(e.d));
                check("R8 captured bad bits", 32'(err_bits), 32'(1 << fault_bit));
                start = 1'b1;     // R1: ignored while halted
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    start = 1'b0;
                    check("R8 no write while halted", 32'(mem_we), 32'd0);
                    check("R8 address frozen", 32'(mem_addr), 32'(e.a));
                    check("R8 err held", 32'(err), 32'd1);
                end
                restart = 1'b1;
            end
            cyc++;
        end
        @(negedge clk);
        start   = 1'b0;
        restart = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; restart = 1'b0;
        first_blk = '0; blk_count = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset err", 32'(err), 32'd0);
        check("R1 reset we", 32'(mem_we), 32'd0);
        check("R1 reset pass count", 32'(pass_cnt), 32'd0);
        check("R1 reset err_addr", 32'(err_addr), 32'd0);
        check("R1 reset err_bits", 32'(err_bits), 32'd0);

        // R1: zero block count does not start.
        first_blk = 4'd3; blk_count = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R1 zero count ignored", 32'(mem_we), 32'd0);
        end

        // Run A: blocks 3,4 over three passes (R2-R7), start/restart pokes ignored.
        first_blk = 4'd3; blk_count = 5'd2;
        build(3, 2, 3);
        start = 1'b1;
        run_queue(300);

        // Reset mid-run returns everything to idle (R1).
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pass count cleared", 32'(pass_cnt), 32'd0);
        check("R1 idle after reset", 32'(mem_we), 32'd0);

        // Run B: blocks 15,0 (wrap, R6), fresh base (R10), fault in block 0 (R8, R9).
        fault_on = 1'b1; fault_addr = 12'h02A; fault_bit = 2;
        first_blk = 4'd15; blk_count = 5'd2;
        build(15, 2, 3);
        start = 1'b1;
        run_queue(-1);
        check("R8 halts observed", 32'(n_halts), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule